// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block collects interrupt requests into a flag register and decides whether the core should be interrupted. It has twelve maskable request lines, numbered 4 to 15, and one non-maskable line. A rising edge on any line sets its flag. Software works on the flags through two write-only strobe registers. One sets the flags it writes ones to. The other clears them. Software never writes the flag word directly.

Each maskable flag is gated by its own enable bit and by a global enable bit before it can raise the pending output. The non-maskable flag bypasses both gates. Writes to the per-line enable register are discarded while the core runs in user mode. The block reports the lowest-numbered eligible line as the interrupt index. When the core takes an interrupt, it presents that index on the acknowledge port, and the block clears the matching flag.

The register bus is a single-cycle write port with a combinational read port on the same address. The register map is: address 0 is the flags (read only), address 1 is the set strobe, address 2 is the clear strobe, address 3 is the per-line enables, and address 4 is the control word, whose bit 0 is the global enable.

Top module: `irq_flag_ctl`

## Requirements
- R1: After reset, the flags, the enables and the global enable are all 0, `irqPending` is 0 and `irqIndex` is 0.
- R2: A 0-to-1 transition on `irqIn[i]`, for i in 4..15, sets flag bit i at that clock edge. The flags read at address 0, in bits 4..15. A line held high does not set its flag again after the flag is cleared.
- R3: A 0-to-1 transition on `nmiIn` sets flag bit 1. The set and clear registers have no effect on bit 1.
- R4: A write to address 1 sets every flag bit 4..15 that is written as 1 and leaves the bits written as 0 unchanged. Reads of address 1 return 0.
- R5: A write to address 2 clears every flag bit 4..15 that is written as 1 and leaves the bits written as 0 unchanged. Reads of address 2 return 0.
- R6: Bits 0, 2 and 3 of the flags, bits 0..3 of the enables, bits 15..1 of the control word and all unmapped addresses (5..7) read as 0. Set or clear writes to these bits change nothing.
- R7: If a line's rising edge and a software clear or acknowledge of the same flag fall in the same cycle, the flag ends up set.
- R8: Writes to address 3 load enable bits 4..15 only while `supervisor` is 1. When `supervisor` is 0, such writes leave the enables unchanged.
- R9: Address 4 bit 0 is the global enable. `irqPending` is 1 when flag 1 is set, or when the global enable is 1 and some flag i in 4..15 and its enable i are both 1.
- R10: A set non-maskable flag raises `irqPending` whatever the global enable and the per-line enables hold.
- R11: `irqIndex` gives the lowest-numbered eligible flag: 1 for the non-maskable flag, otherwise the line number 4..15. It is 0 when nothing is pending.
- R12: When `ackValid` is 1, the flag numbered `ackIndex` is cleared at the clock edge, where 1 selects the non-maskable flag and 4..15 select lines. Any other index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Request lines; bits 4..15 are used |
| nmiIn | input | 1 | Non-maskable request line |
| supervisor | input | 1 | 1 when the core is in supervisor mode |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for write and read |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the addressed register |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackIndex | input | 4 | Number of the flag being serviced |
| irqPending | output | 1 | An eligible interrupt is waiting |
| irqIndex | output | 4 | Lowest-numbered eligible flag |

## Verification
A corrupted flag, enable or global-enable bit shows up at once on the combinational read of its register and on `irqPending`/`irqIndex`, one clock after the edge that wrote it. The bench keeps a shadow of all three words and compares every output on every cycle, so a divergence is caught on the first cycle it exists. A lost edge detect or a wrong priority between event and clear only shows in the cycles where both hit one bit, which is why those collisions are driven on purpose as well as by chance.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [ADDR_W-1:0] {
    A_FLAGS = 3'd0,
    A_SET   = 3'd1,
    A_CLR   = 3'd2,
    A_EN    = 3'd3,
    A_CTL   = 3'd4
  } regAddr_t;

  // strobes from the decode side to the state side
  typedef struct packed {
    logic [DATA_W-1:0] setMask;
    logic [DATA_W-1:0] clrMask;
    logic [DATA_W-1:0] ackMask;
    logic [DATA_W-1:0] enData;
    logic              enWe;
    logic              gieWe;
    logic              gieData;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] lineMask(input int first, input int last);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++)
      if (b >= first && b <= last) m[b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int FIRST_LINE = 4,
  parameter int LAST_LINE  = 15,
  parameter int NMI_POS    = 1
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              supervisor,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIndex,
  output ctlStrobe_t        strobes
);

  localparam logic [DATA_W-1:0] LINE_MASK = lineMask(FIRST_LINE, LAST_LINE);
  localparam logic [DATA_W-1:0] ACK_MASK  = LINE_MASK | (DATA_W'(1) << NMI_POS);

  logic [DATA_W-1:0] ackHit;

  // one comparator per flag position; only real flags may be acknowledged
  for (genvar b = 0; b < DATA_W; b++) begin : g_ack
    if (ACK_MASK[b]) begin : g_hit
      assign ackHit[b] = ackValid && (ackIndex == IDX_W'(b));
    end else begin : g_none
      assign ackHit[b] = 1'b0;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.ackMask = ackHit;
    strobes.enData  = busWrData & LINE_MASK;
    strobes.gieData = busWrData[0];
    if (busWrEn) begin
      case (regAddr_t'(busAddr))
        A_SET:   strobes.setMask = busWrData & LINE_MASK;
        A_CLR:   strobes.clrMask = busWrData & LINE_MASK;
        A_EN:    strobes.enWe    = supervisor;
        A_CTL:   strobes.gieWe   = 1'b1;
        default: ;
      endcase
    end
  end

  // a single bus write drives at most one register action (R4, R5)
  always_comb begin
    p_one_action_r4: assert ($onehot0({|strobes.setMask, |strobes.clrMask,
                                       strobes.enWe, strobes.gieWe}));
  end

endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
#(
  parameter int FIRST_LINE = 4,
  parameter int LAST_LINE  = 15,
  parameter int NMI_POS    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] irqIn,
  input  logic              nmiIn,
  input  ctlStrobe_t        strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPending,
  output logic [IDX_W-1:0]  irqIndex
);

  localparam logic [DATA_W-1:0] LINE_MASK = lineMask(FIRST_LINE, LAST_LINE);
  localparam logic [DATA_W-1:0] NMI_MASK  = DATA_W'(1) << NMI_POS;
  localparam logic [DATA_W-1:0] FLAG_MASK = LINE_MASK | NMI_MASK;

  logic [DATA_W-1:0] flagsQ, flagsD;
  logic [DATA_W-1:0] enQ;
  logic              gieQ;
  logic [DATA_W-1:0] sampleIn, prevQ, evtBits;
  logic [DATA_W-1:0] eligible;

  assign sampleIn = (irqIn & LINE_MASK) | ({DATA_W{nmiIn}} & NMI_MASK);

  // next state per flag position; an arriving edge outranks any clear
  for (genvar b = 0; b < DATA_W; b++) begin : g_flag
    if (FLAG_MASK[b]) begin : g_live
      assign evtBits[b] = sampleIn[b] & ~prevQ[b];
      assign flagsD[b]  = (flagsQ[b] & ~(strobes.clrMask[b] | strobes.ackMask[b]))
                        | strobes.setMask[b] | evtBits[b];
    end else begin : g_dead
      assign evtBits[b] = 1'b0;
      assign flagsD[b]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      prevQ  <= '0;
      enQ    <= '0;
      gieQ   <= 1'b0;
    end else begin
      flagsQ <= flagsD;
      prevQ  <= sampleIn;
      if (strobes.enWe)  enQ  <= strobes.enData & LINE_MASK;
      if (strobes.gieWe) gieQ <= strobes.gieData;
    end
  end

  always_comb begin
    case (regAddr_t'(rdAddr))
      A_FLAGS: rdData = flagsQ;
      A_EN:    rdData = enQ;
      A_CTL:   rdData = {{(DATA_W-1){1'b0}}, gieQ};
      default: rdData = '0;
    endcase
  end

  assign eligible   = (flagsQ & enQ & LINE_MASK & {DATA_W{gieQ}}) | (flagsQ & NMI_MASK);
  assign irqPending = |eligible;

  // fixed priority: lowest number wins
  always_comb begin
    irqIndex = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (eligible[i]) irqIndex = IDX_W'(i);
  end

  p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((flagsQ & ~FLAG_MASK) == '0) && ((enQ & ~LINE_MASK) == '0));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|evtBits) |=> ((flagsQ & $past(evtBits)) == $past(evtBits)));

  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobes.clrMask & ~evtBits)) |=> ((flagsQ & $past(strobes.clrMask & ~evtBits)) == '0));

  p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.enWe |=> $stable(enQ));

  p_gie_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!gieQ && !flagsQ[NMI_POS]) |-> !irqPending);

  p_nmi_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagsQ[NMI_POS] |-> (irqPending && irqIndex == IDX_W'(NMI_POS)));

  p_idle_index_r11: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> (irqIndex == '0));

endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_flag_pkg::*;
#(
  parameter int FIRST_LINE = 4,
  parameter int LAST_LINE  = 15,
  parameter int NMI_POS    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] irqIn,
  input  logic              nmiIn,
  input  logic              supervisor,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIndex,
  output logic              irqPending,
  output logic [IDX_W-1:0]  irqIndex
);

  ctlStrobe_t strobes;

  irq_flag_ctrl #(.FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE), .NMI_POS(NMI_POS)) u_ctrl (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .supervisor(supervisor),
    .ackValid  (ackValid),
    .ackIndex  (ackIndex),
    .strobes   (strobes)
  );

  irq_flag_dp #(.FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE), .NMI_POS(NMI_POS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .nmiIn     (nmiIn),
    .strobes   (strobes),
    .rdAddr    (busAddr),
    .rdData    (busRdData),
    .irqPending(irqPending),
    .irqIndex  (irqIndex)
  );

  // a user-mode write to the enables leaves their readback unchanged (R8)
  p_user_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_EN && !supervisor) |=> (busAddr != A_EN || busWrEn || $stable(busRdData)));

endmodule

// File: tb/tb_irq_flag_ctl.sv
module tb_irq_flag_ctl;

  localparam logic [15:0] MASK_M = 16'hFFF0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic        nmiIn = 1'b0;
  logic        supervisor = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        ackValid = 1'b0;
  logic [3:0]  ackIndex = '0;
  logic        irqPending;
  logic [3:0]  irqIndex;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // shadow state
  logic [15:0] mFlags = '0, mEn = '0, mPrev = '0;
  logic        mGie = 1'b0;

  irq_flag_ctl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .nmiIn(nmiIn), .supervisor(supervisor),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .ackValid(ackValid), .ackIndex(ackIndex), .irqPending(irqPending), .irqIndex(irqIndex)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] expRead(input logic [2:0] a);
    case (a)
      3'd0:    return mFlags;
      3'd3:    return mEn;
      3'd4:    return {15'd0, mGie};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] expEligible();
    return (mFlags & mEn & MASK_M & {16{mGie}}) | (mFlags & 16'h0002);
  endfunction

  function automatic logic [3:0] expIndex();
    logic [15:0] e;
    e = expEligible();
    for (int i = 15; i >= 0; i--) if (e[i]) return 4'(i) == 4'(i) ? lowest(e) : 4'd0;
    return 4'd0;
  endfunction

  function automatic logic [3:0] lowest(input logic [15:0] e);
    for (int i = 0; i < 16; i++) if (e[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [15:0] samp, evt, setM, clrM, ackM;
    samp = (irqIn & MASK_M) | {14'd0, nmiIn, 1'b0};
    evt  = samp & ~mPrev;
    setM = (busWrEn && busAddr == 3'd1) ? (busWrData & MASK_M) : 16'd0;
    clrM = (busWrEn && busAddr == 3'd2) ? (busWrData & MASK_M) : 16'd0;
    ackM = 16'd0;
    if (ackValid && (ackIndex == 4'd1 || ackIndex >= 4'd4)) ackM = 16'd1 << ackIndex;
    mFlags = (mFlags & ~(clrM | ackM)) | setM | evt;
    if (busWrEn && busAddr == 3'd3 && supervisor) mEn = busWrData & MASK_M;
    if (busWrEn && busAddr == 3'd4) mGie = busWrData[0];
    mPrev = samp;
  endtask

  // drive one cycle, check the current outputs, then advance the shadow
  task automatic step(input string tag, input logic [15:0] irq, input logic nmi,
                      input logic we, input logic [2:0] a, input logic [15:0] wd,
                      input logic sup, input logic ackV, input logic [3:0] ackI);
    @(negedge clk);
    irqIn = irq; nmiIn = nmi; busWrEn = we; busAddr = a; busWrData = wd;
    supervisor = sup; ackValid = ackV; ackIndex = ackI;
    #1;
    check({tag, " read"}, busRdData, expRead(a));
    check({tag, " pending"}, {15'd0, irqPending}, {15'd0, |expEligible()});
    check({tag, " index"}, {12'd0, irqIndex}, {12'd0, lowest(expEligible())});
    modelStep();
  endtask

  task automatic peek(input string tag, input logic [2:0] a);
    step(tag, irqIn, nmiIn, 1'b0, a, 16'd0, supervisor, 1'b0, 4'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rIrq;
    logic        rNmi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and output
    peek("R1 flags", 3'd0);
    peek("R1 enables", 3'd3);
    peek("R1 control", 3'd4);
    check("R1 pending", {15'd0, irqPending}, 16'd0);

    // R4: set strobe, zeros leave others alone; R6: bits 0..3 untouched
    step("R4 set", 16'h0, 1'b0, 1'b1, 3'd1, 16'hFFFF, 1'b1, 1'b0, 4'd0);
    peek("R6 flags low", 3'd0);
    check("R6 low bits", busRdData & 16'h000F, 16'd0);
    peek("R4 set readback", 3'd1);
    // R5: clear strobe
    step("R5 clear", 16'h0, 1'b0, 1'b1, 3'd2, 16'h00F0, 1'b1, 1'b0, 4'd0);
    step("R5 clear zero", 16'h0, 1'b0, 1'b1, 3'd2, 16'h0000, 1'b1, 1'b0, 4'd0);
    peek("R5 flags", 3'd0);
    check("R5 flags value", busRdData, 16'hFF00);

    // R8: user-mode enable write dropped, supervisor write taken
    step("R8 user write", 16'h0, 1'b0, 1'b1, 3'd3, 16'hFFFF, 1'b0, 1'b0, 4'd0);
    peek("R8 enables", 3'd3);
    check("R8 locked", busRdData, 16'h0000);
    step("R8 sup write", 16'h0, 1'b0, 1'b1, 3'd3, 16'h0F0F, 1'b1, 1'b0, 4'd0);
    peek("R8 enables after", 3'd3);
    check("R8 loaded", busRdData, 16'h0F00);

    // R9: global enable gates maskable lines; R11 lowest line index
    peek("R9 gie off", 3'd4);
    check("R9 gated", {15'd0, irqPending}, 16'd0);
    step("R9 gie on", 16'h0, 1'b0, 1'b1, 3'd4, 16'h0001, 1'b1, 1'b0, 4'd0);
    peek("R11 index", 3'd0);
    check("R11 lowest", {12'd0, irqIndex}, 16'd8);

    // R12: acknowledge clears the serviced line
    step("R12 ack", 16'h0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 4'd8);
    peek("R12 after ack", 3'd0);
    check("R12 next index", {12'd0, irqIndex}, 16'd9);
    step("R12 ack bad index", 16'h0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 4'd2);

    // R7: edge and clear on line 12 in the same cycle
    step("R7 prep clear", 16'h0, 1'b0, 1'b1, 3'd2, 16'hFFF0, 1'b1, 1'b0, 4'd0);
    step("R7 collide", 16'h1000, 1'b0, 1'b1, 3'd2, 16'h1000, 1'b1, 1'b0, 4'd0);
    peek("R7 flags", 3'd0);
    check("R7 event wins", busRdData, 16'h1000);
    // R7 with acknowledge on line 13
    step("R7 ack collide", 16'h3000, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 4'd13);
    peek("R7 ack flags", 3'd0);
    check("R7 ack event wins", busRdData, 16'h3000);

    // R2: held line does not re-arm after clear
    step("R2 clear held", 16'h3000, 1'b0, 1'b1, 3'd2, 16'h3000, 1'b1, 1'b0, 4'd0);
    peek("R2 held", 3'd0);
    check("R2 no re-set", busRdData, 16'h0000);
    step("R2 drop", 16'h0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 4'd0);
    step("R2 rise", 16'h0010, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 4'd0);
    peek("R2 captured", 3'd0);
    check("R2 line 4", busRdData, 16'h0010);

    // R10 / R3: NMI with global enable off; set/clear cannot touch bit 1
    step("R10 gie off", 16'h0, 1'b0, 1'b1, 3'd4, 16'h0000, 1'b1, 1'b0, 4'd0);
    step("R3 nmi rise", 16'h0, 1'b1, 1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 4'd0);
    peek("R10 nmi pending", 3'd0);
    check("R10 pending", {15'd0, irqPending}, 16'd1);
    check("R3 index", {12'd0, irqIndex}, 16'd1);
    step("R3 clear bit1", 16'h0, 1'b1, 1'b1, 3'd2, 16'h0002, 1'b1, 1'b0, 4'd0);
    peek("R3 still set", 3'd0);
    check("R3 bit1 kept", busRdData & 16'h0002, 16'h0002);
    step("R12 nmi ack", 16'h0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 4'd1);
    peek("R12 nmi cleared", 3'd0);
    check("R12 nmi gone", busRdData & 16'h0002, 16'h0000);
    peek("R6 unmapped", 3'd6);

    // random traffic
    rIrq = '0; rNmi = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] wd;
      logic [2:0]  a;
      if ($urandom_range(0, 3) == 0) rIrq = rIrq ^ (16'd1 << $urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) rNmi = ~rNmi;
      wd = 16'($urandom);
      a  = 3'($urandom_range(0, 7));
      step("R9 random", rIrq, rNmi, $urandom_range(0, 9) < 3, a, wd,
           1'($urandom), $urandom_range(0, 4) == 0, 4'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule